// File: doc/BRIEF.md
# Edge-Configurable Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt line. Each source has its own channel. A channel can capture its input on a rising edge or on a high level. A capture is allowed only while the channel's mask bit is set. Each capture sets a bit in a sticky pending register, and software clears a pending bit by writing a 1 to it. The pending bits that the enable register allows are combined onto the single output `irq_out`. Software chooses whether that output is a level or a one-clock pulse each time a new enabled interrupt arrives.

Software reaches the controller through a small word-addressed register bus. Writes take effect at the clock edge that samples them. Reads return their data one cycle after the request. Two software-request registers can inject interrupts. Writing 1 and then 0 to one of them drives a high pulse onto a chosen channel's source. Reading back the enable register gives software a simple way to make sure that earlier writes have landed.

Top module: `edgeirq_ctrl`

## Requirements
- R1: After the synchronous active-high reset, every register reads 0 and `irq_out` is 0.
- R2: Register word addresses are: 0 capture-mode, 1 mask, 2 pending, 3 enable, 4 clear, 5 output-mode, 6 software request A, 7 software request B. Read data appears on `rdata` one cycle after `rd_en`. Bits at or above NUM_CH read 0, and the clear register reads 0. Reading the enable register returns its last written value.
- R3: A channel whose mask bit is 0 never sets its pending bit, whatever its input does.
- R4: A channel whose capture-mode bit is 1 sets its pending bit only on a rising edge of its source. If the source is held high after a clear, the bit does not set again.
- R5: A channel whose capture-mode bit is 0 sets its pending bit on every clock in which its masked source is high.
- R6: Writing the clear register clears exactly the pending bits written as 1. Bits written above NUM_CH have no effect.
- R7: When a clear and a new capture hit the same channel in the same cycle, the pending bit stays set.
- R8: When the output-mode register is 0 (level), `irq_out` is the OR of pending AND enable, delayed by one clock.
- R9: When any output-mode bit is 1 (pulse), `irq_out` is high for exactly one clock, one cycle after a cycle in which the enabled pending set gains a new bit. Pending bits that are not enabled never pulse it.
- R10: Writing 1 and then 0 to software request A drives a high pulse onto channel SW_A_CH (default 0). Software request B does the same for channel SW_B_CH (default 1). The pulse is ORed with the external source of that channel.
- R11: The pending register cannot be written through the bus. A write to address 2 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_CH | Interrupt sources, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The hardest case to reach is a clear and a fresh capture landing on the same channel in the same clock. The stimulus gets there by putting a channel in level capture, holding its source high, and then writing the clear register. The clear strobe and the level hit then coincide at one edge. A related case needs an edge-capture channel to stay silent while its source is held high across a clear. This is reached by raising the source before the clear write and leaving it up afterwards. The sweep over every channel, both capture modes and both mask values forces both cases on each bit.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CAPMODE = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_PEND    = 3'd2,
    SEL_ENABLE  = 3'd3,
    SEL_CLEAR   = 3'd4,
    SEL_OUTMODE = 3'd5,
    SEL_SWREQ_A = 3'd6,
    SEL_SWREQ_B = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/edgeirq_regs.sv
module edgeirq_regs
  import edgeirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] status,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] edge_sel,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] enable,
  output logic [NUM_CH-1:0] out_mode,
  output logic [1:0]        sw_req,
  output logic [NUM_CH-1:0] clr_vec
);
  reg_sel_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(addr);
  assign clr_vec = (wr_en && sel == SEL_CLEAR) ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel <= '0;
      mask     <= '0;
      enable   <= '0;
      out_mode <= '0;
      sw_req   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CAPMODE: edge_sel  <= wdata[NUM_CH-1:0];
        SEL_MASK:    mask      <= wdata[NUM_CH-1:0];
        SEL_ENABLE:  enable    <= wdata[NUM_CH-1:0];
        SEL_OUTMODE: out_mode  <= wdata[NUM_CH-1:0];
        SEL_SWREQ_A: sw_req[0] <= wdata[0];
        SEL_SWREQ_B: sw_req[1] <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CAPMODE: rd_mux[NUM_CH-1:0] = edge_sel;
      SEL_MASK:    rd_mux[NUM_CH-1:0] = mask;
      SEL_PEND:    rd_mux[NUM_CH-1:0] = status;
      SEL_ENABLE:  rd_mux[NUM_CH-1:0] = enable;
      SEL_OUTMODE: rd_mux[NUM_CH-1:0] = out_mode;
      SEL_SWREQ_A: rd_mux[0]          = sw_req[0];
      SEL_SWREQ_B: rd_mux[0]          = sw_req[1];
      default:     rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/edgeirq_capture.sv
module edgeirq_capture #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] raw_vec,
  input  logic [NUM_CH-1:0] edge_sel,
  input  logic [NUM_CH-1:0] mask,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] status
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic prev_q;
    logic hit;

    assign hit = mask[g] & (edge_sel[g] ? (raw_vec[g] & ~prev_q) : raw_vec[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q    <= 1'b0;
        status[g] <= 1'b0;
      end else begin
        prev_q    <= raw_vec[g];
        status[g] <= (status[g] & ~clr_vec[g]) | hit;
      end
    end
  end
endmodule

// File: rtl/edgeirq_out.sv
module edgeirq_out #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] status,
  input  logic [NUM_CH-1:0] enable,
  input  logic              pulse_mode,
  output logic              irq_out
);
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] pend_q;

  assign pend = status & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      pend_q  <= pend;
      irq_out <= pulse_mode ? |(pend & ~pend_q) : |pend;
    end
  end
endmodule

// File: rtl/edgeirq_ctrl.sv
module edgeirq_ctrl
  import edgeirq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 32,
  parameter int SW_A_CH = 0,
  parameter int SW_B_CH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);
  logic [NUM_CH-1:0] edge_sel, mask, enable, out_mode, clr_vec, status;
  logic [NUM_CH-1:0] sw_vec, raw_vec;
  logic [1:0]        sw_req;
  logic              pulse_mode;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sw
    assign sw_vec[i] = ((i == SW_A_CH) && sw_req[0]) || ((i == SW_B_CH) && sw_req[1]);
  end

  assign raw_vec    = irq_in | sw_vec;
  assign pulse_mode = |out_mode;

  edgeirq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status), .rdata(rdata), .edge_sel(edge_sel),
    .mask(mask), .enable(enable), .out_mode(out_mode), .sw_req(sw_req),
    .clr_vec(clr_vec)
  );

  edgeirq_capture #(.NUM_CH(NUM_CH)) cap_i (
    .clk(clk), .rst(rst), .raw_vec(raw_vec), .edge_sel(edge_sel),
    .mask(mask), .clr_vec(clr_vec), .status(status)
  );

  edgeirq_out #(.NUM_CH(NUM_CH)) out_i (
    .clk(clk), .rst(rst), .status(status), .enable(enable),
    .pulse_mode(pulse_mode), .irq_out(irq_out)
  );
endmodule

// File: rtl/edgeirq_chk.sv
module edgeirq_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] raw_vec,
  input logic [NUM_CH-1:0] edge_sel,
  input logic [NUM_CH-1:0] mask,
  input logic [NUM_CH-1:0] enable,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] clr_vec,
  input logic              pulse_mode,
  input logic              irq_out
);
  logic [NUM_CH-1:0] pend;
  assign pend = status & enable;

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status) & ~$past(mask)) == '0)); // R3

  AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~status & ~$past(clr_vec)) == '0)); // R6

  AST_LEVEL_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (($past(mask & ~edge_sel & raw_vec) & ~status) == '0)); // R7

  AST_LEVEL_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !$past(pulse_mode) |-> (irq_out == |$past(pend))); // R8

  AST_PULSE_NEEDS_NEW: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_mode) && irq_out) |-> |($past(pend) & ~$past(pend, 2))); // R9
endmodule

bind edgeirq_ctrl edgeirq_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .raw_vec(raw_vec), .edge_sel(edge_sel), .mask(mask),
  .enable(enable), .status(status), .clr_vec(clr_vec),
  .pulse_mode(pulse_mode), .irq_out(irq_out)
);

// File: tb/edgeirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module edgeirq_ctrl_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam logic [2:0] A_CAP = 3'd0, A_MSK = 3'd1, A_PND = 3'd2, A_ENA = 3'd3,
                         A_CLR = 3'd4, A_MOD = 3'd5, A_SWA = 3'd6, A_SWB = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] irq_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_out;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  edgeirq_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq_out after reset", {31'b0, irq_out}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      check("R1 register reset value", d, 0);
    end

    // R2 register map and readback
    wr(A_ENA, 32'hFFFF_FF5A);
    rd(A_ENA, d); check("R2 enable readback truncated", d, 32'h5A);
    wr(A_CAP, 32'h0000_00C3);
    rd(A_CAP, d); check("R2 capture-mode readback", d, 32'hC3);
    rd(A_CLR, d); check("R2 clear reads zero", d, 0);
    wr(A_ENA, 0); wr(A_CAP, 0);

    // R11 pending not writable
    wr(A_PND, 32'hFF);
    rd(A_PND, d); check("R11 pending write ignored", d, 0);

    // Sweep: every channel, both capture modes, both mask values
    for (int ch = 0; ch < NCH; ch++) begin
      for (int eb = 0; eb < 2; eb++) begin
        for (int mb = 0; mb < 2; mb++) begin
          logic [DW-1:0] bit_ch;
          bit_ch = 32'd1 << ch;
          wr(A_CAP, eb ? bit_ch : 0);
          wr(A_MSK, mb ? bit_ch : 0);
          wr(A_CLR, 32'hFF);
          irq_in = bit_ch[NCH-1:0];
          idle(2);
          irq_in = '0;
          idle(2);
          rd(A_PND, d);
          check(mb ? (eb ? "R4 edge capture" : "R5 level capture") : "R3 masked channel",
                d, mb ? bit_ch : 0);
          if (mb) begin
            irq_in = bit_ch[NCH-1:0];
            idle(2);
            wr(A_CLR, bit_ch);
            idle(2);
            rd(A_PND, d);
            check(eb ? "R4 held high no recapture" : "R7 level set beats clear",
                  d, eb ? 0 : bit_ch);
            irq_in = '0;
          end
          wr(A_CLR, 32'hFF);
        end
      end
    end

    // R6 exact clear, upper bits ignored
    wr(A_CAP, 32'hFF); wr(A_MSK, 32'hFF);
    irq_in = 8'hFF; idle(2); irq_in = '0; idle(1);
    rd(A_PND, d); check("R6 all pending", d, 32'hFF);
    wr(A_CLR, 32'hFFFF_FF00);
    rd(A_PND, d); check("R6 upper clear bits no effect", d, 32'hFF);
    wr(A_CLR, 32'h24);
    rd(A_PND, d); check("R6 clear exact bits", d, 32'hDB);
    wr(A_CLR, 32'hFF);

    // R7 explicit on channel 0
    wr(A_CAP, 0); wr(A_MSK, 32'h01);
    irq_in = 8'h01; idle(1);
    wr(A_CLR, 32'h01);
    rd(A_PND, d); check("R7 set wins over clear", d, 32'h01);
    irq_in = '0; wr(A_CLR, 32'hFF);

    // R8 level output
    wr(A_CAP, 32'hFF); wr(A_MSK, 32'hFF); wr(A_MOD, 0); wr(A_ENA, 32'h08);
    irq_in = 8'h04; idle(1); irq_in = '0; idle(2);
    check("R8 non-enabled pending no output", {31'b0, irq_out}, 0);
    irq_in = 8'h08;
    @(negedge clk); check("R8 output lags pending", {31'b0, irq_out}, 0);
    irq_in = '0;
    @(negedge clk); check("R8 level high", {31'b0, irq_out}, 1);
    @(negedge clk); check("R8 level held", {31'b0, irq_out}, 1);
    wr(A_CLR, 32'h08);
    @(negedge clk); check("R8 level drops after clear", {31'b0, irq_out}, 0);

    // R9 pulse output
    wr(A_CLR, 32'hFF); wr(A_MOD, 32'hFF); wr(A_ENA, 32'h0C);
    idle(1);
    irq_in = 8'h04;
    @(negedge clk); check("R9 pulse not yet", {31'b0, irq_out}, 0);
    irq_in = '0;
    @(negedge clk); check("R9 pulse high", {31'b0, irq_out}, 1);
    @(negedge clk); check("R9 pulse one cycle", {31'b0, irq_out}, 0);
    @(negedge clk); check("R9 pulse stays low", {31'b0, irq_out}, 0);
    irq_in = 8'h08;
    @(negedge clk); check("R9 second pulse not yet", {31'b0, irq_out}, 0);
    irq_in = '0;
    @(negedge clk); check("R9 second pulse high", {31'b0, irq_out}, 1);
    @(negedge clk); check("R9 second pulse ends", {31'b0, irq_out}, 0);
    irq_in = 8'h01;
    @(negedge clk); irq_in = '0;
    @(negedge clk); check("R9 non-enabled no pulse", {31'b0, irq_out}, 0);
    @(negedge clk); check("R9 non-enabled no pulse later", {31'b0, irq_out}, 0);
    wr(A_MOD, 0);
    @(negedge clk); check("R8 back to level shows pending", {31'b0, irq_out}, 1);

    // R10 software requests
    wr(A_ENA, 0); wr(A_CLR, 32'hFF);
    wr(A_SWA, 1); wr(A_SWA, 0);
    rd(A_PND, d); check("R10 request A sets channel 0", d, 32'h01);
    wr(A_SWB, 1); wr(A_SWB, 0);
    rd(A_PND, d); check("R10 request B sets channel 1", d, 32'h03);
    rd(A_SWA, d); check("R10 request A reads back 0", d, 0);
    wr(A_CLR, 32'hFF); wr(A_MSK, 0);
    wr(A_SWA, 1); wr(A_SWA, 0);
    rd(A_PND, d); check("R10 masked request no capture", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule